// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block turns decoded host requests into the command pins of a single-rank SDRAM: chip select, row strobe, column strobe, write enable, bank select and an 11-bit address. A request is one of four operations: an access (write or read), a load of the memory's mode register, a precharge of all banks, or an auto refresh. A separate level-sensitive refresh request, raised by an external refresh timer, is answered with a one-cycle clear pulse issued together with the refresh command.

An access opens a row with an activate command. It then waits out a programmable row-to-column delay and issues a write or read that always carries auto precharge. For a write, the block raises a write-data enable for every beat, starting in the cycle of the write command. For a read, it waits a programmable latency and then raises a read-capture window for every beat. The row-to-column delay, the latency and the burst length come from configuration inputs. The block captures all three when it accepts the request. It pulses a completion flag in the first idle cycle after every operation. The data path, clock generation and refresh interval timing live outside this block.

Top module: `sdram_cmd_seq`

## Requirements
- R1: The sequencer is always in exactly one state. During reset, and in every idle cycle with nothing pending, it drives NOP (cs_n, ras_n, cas_n, we_n = 0,1,1,1) with address 0 and bank 0, and `wr_data_en`, `rd_capture`, `ref_clr` and `op_done` are all low.
- R2: Operation code 2'b10 issues exactly one precharge command (0,0,1,0) in the cycle after acceptance. This command has address bit 10 set, all other address bits 0, and bank 0.
- R3: Operation code 2'b01 issues exactly one mode-register command (0,0,0,0) in the cycle after acceptance. Its address equals `req_row` and its bank is 0.
- R4: Operation code 2'b11, or a refresh taken from `ref_req`, issues a refresh command (0,0,0,1) with `ref_clr` high in the same cycle. It is followed by exactly one NOP cycle with `ref_clr` low before the block returns to idle.
- R5: When `ref_req` is high in an idle cycle, the refresh starts and any `req_valid` in that cycle is not accepted. That request is taken in a later idle cycle once `ref_req` is low.
- R6: Operation code 2'b00 issues an activate command (0,0,1,1) in the cycle after acceptance, carrying `req_bank` on the bank pin and `req_row` on the address. It is followed by cfg_rcd+1 NOP cycles.
- R7: A write access then issues a write command (0,1,0,0) with bank `req_bank`, address bit 10 set and `req_col` in address bits 7:0. `wr_data_en` is high for cfg_burst+1 consecutive cycles, beginning with that command cycle. The burst cycles after the command drive NOP.
- R8: A read access then issues a read command (0,1,0,1) with bank `req_bank`, address bit 10 set and `req_col` in address bits 7:0. This is followed by cfg_cas NOP cycles, where cfg_cas is the memory latency minus one. `rd_capture` is then high for cfg_burst+1 consecutive NOP cycles, where cfg_burst is the burst length minus one.
- R9: `op_done` is high for exactly one cycle: the first idle cycle after each operation, refreshes included.
- R10: `req_accept` is high exactly in idle cycles with `req_valid` high and `ref_req` low. Requests presented while an operation runs are ignored and cause no command.
- R11: The configuration inputs and request fields are captured at acceptance. Changing them during an operation does not change its commands or enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising-edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_op | input | 2 | 00 access, 01 load mode, 10 precharge all, 11 refresh |
| req_write | input | 1 | Access direction, 1 = write |
| req_bank | input | 1 | Bank of the access |
| req_row | input | 11 | Row of the access, or mode value for a load |
| req_col | input | 8 | Starting column of the access |
| cfg_rcd | input | 2 | Extra row-to-column wait cycles |
| cfg_cas | input | 2 | Read latency minus one |
| cfg_burst | input | 3 | Burst length minus one |
| ref_req | input | 1 | Refresh timer request, level |
| req_accept | output | 1 | Request taken this cycle |
| ref_clr | output | 1 | Refresh request clear pulse |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 1 | Bank select |
| sd_addr | output | 11 | Memory address |
| wr_data_en | output | 1 | Write data beat enable |
| rd_capture | output | 1 | Read data capture window |
| op_done | output | 1 | Operation complete pulse |

## Verification
The first command of any operation is due in the cycle after the rising edge that accepts it. Activate is followed by cfg_rcd+1 wait cycles before the column command. Read data is due cfg_cas+1 cycles after the read command, and completion comes in the cycle after the last beat. The bench's reference model expands each accepted operation into a queue of per-cycle expected pin values at the accepting edge, pops one entry per rising edge, and compares it with the design's outputs at the falling edge, where every register involved has settled. `req_accept` is compared in the same cycle against the model's own idle flag and the stimulus.

// File: rtl/sdseq_pkg.sv
package sdseq_pkg;

    typedef enum logic [12:0] {
        ST_IDLE     = 13'b0000000000001,
        ST_PREALL   = 13'b0000000000010,
        ST_LOADMODE = 13'b0000000000100,
        ST_AR       = 13'b0000000001000,
        ST_AR2      = 13'b0000000010000,
        ST_ACT      = 13'b0000000100000,
        ST_WR_WAIT  = 13'b0000001000000,
        ST_WR_CMD   = 13'b0000010000000,
        ST_WR_BURST = 13'b0000100000000,
        ST_RD_WAIT  = 13'b0001000000000,
        ST_RD_CMD   = 13'b0010000000000,
        ST_RD_LAT   = 13'b0100000000000,
        ST_RD_BURST = 13'b1000000000000
    } state_e;

    typedef enum logic [1:0] {
        OP_ACCESS   = 2'b00,
        OP_LOADMODE = 2'b01,
        OP_PREALL   = 2'b10,
        OP_REFRESH  = 2'b11
    } op_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_NOP     = '{1'b0, 1'b1, 1'b1, 1'b1};
    localparam cmd_t CMD_ACT     = '{1'b0, 1'b0, 1'b1, 1'b1};
    localparam cmd_t CMD_READ    = '{1'b0, 1'b1, 1'b0, 1'b1};
    localparam cmd_t CMD_WRITE   = '{1'b0, 1'b1, 1'b0, 1'b0};
    localparam cmd_t CMD_PRE     = '{1'b0, 1'b0, 1'b1, 1'b0};
    localparam cmd_t CMD_REFRESH = '{1'b0, 1'b0, 1'b0, 1'b1};
    localparam cmd_t CMD_MODE    = '{1'b0, 1'b0, 1'b0, 1'b0};

endpackage

// File: rtl/sdseq_fsm.sv
module sdseq_fsm
    import sdseq_pkg::*;
#(
    parameter int BANK_W = 1,
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8,
    parameter int RCD_W  = 2,
    parameter int CAS_W  = 2,
    parameter int BL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  op_e               req_op,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [RCD_W-1:0]  cfg_rcd,
    input  logic [CAS_W-1:0]  cfg_cas,
    input  logic [BL_W-1:0]   cfg_burst,
    input  logic              ref_req,
    output state_e            state_q,
    output logic [BANK_W-1:0] bank_q,
    output logic [ADDR_W-1:0] row_q,
    output logic [COL_W-1:0]  col_q,
    output logic              done_q,
    output logic              req_accept
);

    localparam int CNT_A = (RCD_W > CAS_W) ? RCD_W : CAS_W;
    localparam int CNT_W = (CNT_A > BL_W) ? CNT_A : BL_W;

    typedef struct packed {
        state_e            state;
        logic [CNT_W-1:0]  cnt;
        logic [CAS_W-1:0]  cas;
        logic [BL_W-1:0]   bl;
        logic              write;
        logic [BANK_W-1:0] bank;
        logic [ADDR_W-1:0] row;
        logic [COL_W-1:0]  col;
        logic              done;
    } regs_t;

    regs_t q, d;
    logic  cnt_zero;

    always_comb begin
        d          = q;
        cnt_zero   = (q.cnt == '0);
        req_accept = (q.state == ST_IDLE) && req_valid && !ref_req;
        unique case (q.state)
            ST_IDLE: begin
                if (ref_req) begin
                    d.state = ST_AR;
                end else if (req_valid) begin
                    d.bank  = req_bank;
                    d.row   = req_row;
                    d.col   = req_col;
                    d.write = req_write;
                    d.cas   = cfg_cas;
                    d.bl    = cfg_burst;
                    d.cnt   = CNT_W'(cfg_rcd);
                    case (req_op)
                        OP_PREALL:   d.state = ST_PREALL;
                        OP_LOADMODE: d.state = ST_LOADMODE;
                        OP_REFRESH:  d.state = ST_AR;
                        default:     d.state = ST_ACT;
                    endcase
                end
            end
            ST_PREALL, ST_LOADMODE, ST_AR2: d.state = ST_IDLE;
            ST_AR:  d.state = ST_AR2;
            ST_ACT: d.state = q.write ? ST_WR_WAIT : ST_RD_WAIT;
            ST_WR_WAIT, ST_RD_WAIT: begin
                if (cnt_zero) d.state = (q.state == ST_WR_WAIT) ? ST_WR_CMD : ST_RD_CMD;
                else          d.cnt   = q.cnt - CNT_W'(1);
            end
            ST_WR_CMD: begin
                if (q.bl == '0) begin
                    d.state = ST_IDLE;
                end else begin
                    d.state = ST_WR_BURST;
                    d.cnt   = CNT_W'(q.bl) - CNT_W'(1);
                end
            end
            ST_WR_BURST, ST_RD_BURST: begin
                if (cnt_zero) d.state = ST_IDLE;
                else          d.cnt   = q.cnt - CNT_W'(1);
            end
            ST_RD_CMD: begin
                if (q.cas == '0) begin
                    d.state = ST_RD_BURST;
                    d.cnt   = CNT_W'(q.bl);
                end else begin
                    d.state = ST_RD_LAT;
                    d.cnt   = CNT_W'(q.cas) - CNT_W'(1);
                end
            end
            ST_RD_LAT: begin
                if (cnt_zero) begin
                    d.state = ST_RD_BURST;
                    d.cnt   = CNT_W'(q.bl);
                end else begin
                    d.cnt = q.cnt - CNT_W'(1);
                end
            end
            default: d.state = ST_IDLE;
        endcase
        d.done = (d.state == ST_IDLE) && (q.state != ST_IDLE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign state_q = q.state;
    assign bank_q  = q.bank;
    assign row_q   = q.row;
    assign col_q   = q.col;
    assign done_q  = q.done;

    assert_state_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(q.state) == 1);

    assert_refresh_two_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_AR) |=> (q.state == ST_AR2));

    assert_refresh_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE && ref_req) |=> (q.state == ST_AR));

    assert_act_then_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_ACT) |=> (q.state == ST_WR_WAIT || q.state == ST_RD_WAIT));

    assert_fields_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != ST_IDLE) |=> ($stable(q.row) && $stable(q.col) && $stable(q.bank)));

endmodule

// File: rtl/sdseq_cmd_encode.sv
module sdseq_cmd_encode
    import sdseq_pkg::*;
#(
    parameter int BANK_W = 1,
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8,
    parameter int AP_BIT = 10
) (
    input  state_e            state,
    input  logic [BANK_W-1:0] bank,
    input  logic [ADDR_W-1:0] row,
    input  logic [COL_W-1:0]  col,
    output cmd_t              cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              wr_en,
    output logic              rd_cap,
    output logic              ref_clr
);

    localparam logic [ADDR_W-1:0] AP_MASK = ADDR_W'(1) << AP_BIT;

    logic [ADDR_W-1:0] col_addr;
    assign col_addr = ADDR_W'(col) | AP_MASK;

    always_comb begin
        cmd     = CMD_NOP;
        ba      = '0;
        addr    = '0;
        wr_en   = 1'b0;
        rd_cap  = 1'b0;
        ref_clr = 1'b0;
        unique case (state)
            ST_PREALL: begin
                cmd  = CMD_PRE;
                addr = AP_MASK;
            end
            ST_LOADMODE: begin
                cmd  = CMD_MODE;
                addr = row;
            end
            ST_AR: begin
                cmd     = CMD_REFRESH;
                ref_clr = 1'b1;
            end
            ST_ACT: begin
                cmd  = CMD_ACT;
                ba   = bank;
                addr = row;
            end
            ST_WR_CMD: begin
                cmd   = CMD_WRITE;
                ba    = bank;
                addr  = col_addr;
                wr_en = 1'b1;
            end
            ST_WR_BURST: wr_en = 1'b1;
            ST_RD_CMD: begin
                cmd  = CMD_READ;
                ba   = bank;
                addr = col_addr;
            end
            ST_RD_BURST: rd_cap = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdseq_pkg::*;
#(
    parameter int BANK_W = 1,
    parameter int ADDR_W = 11,
    parameter int COL_W  = 8,
    parameter int AP_BIT = 10,
    parameter int RCD_W  = 2,
    parameter int CAS_W  = 2,
    parameter int BL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_op,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ADDR_W-1:0] req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [RCD_W-1:0]  cfg_rcd,
    input  logic [CAS_W-1:0]  cfg_cas,
    input  logic [BL_W-1:0]   cfg_burst,
    input  logic              ref_req,
    output logic              req_accept,
    output logic              ref_clr,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ADDR_W-1:0] sd_addr,
    output logic              wr_data_en,
    output logic              rd_capture,
    output logic              op_done
);

    state_e            state;
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] row;
    logic [COL_W-1:0]  col;
    cmd_t              cmd;

    sdseq_fsm #(
        .BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W),
        .RCD_W(RCD_W), .CAS_W(CAS_W), .BL_W(BL_W)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(op_e'(req_op)),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cfg_rcd(cfg_rcd), .cfg_cas(cfg_cas), .cfg_burst(cfg_burst), .ref_req(ref_req),
        .state_q(state), .bank_q(bank), .row_q(row), .col_q(col),
        .done_q(op_done), .req_accept(req_accept)
    );

    sdseq_cmd_encode #(
        .BANK_W(BANK_W), .ADDR_W(ADDR_W), .COL_W(COL_W), .AP_BIT(AP_BIT)
    ) enc_i (
        .state(state), .bank(bank), .row(row), .col(col),
        .cmd(cmd), .ba(sd_ba), .addr(sd_addr),
        .wr_en(wr_data_en), .rd_cap(rd_capture), .ref_clr(ref_clr)
    );

    assign sd_cs_n  = cmd.cs_n;
    assign sd_ras_n = cmd.ras_n;
    assign sd_cas_n = cmd.cas_n;
    assign sd_we_n  = cmd.we_n;

    assert_write_opens_burst_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_data_en) |-> (!sd_cs_n && sd_ras_n && !sd_cas_n && !sd_we_n && sd_addr[AP_BIT]));

    assert_read_excludes_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sd_cs_n && sd_ras_n && !sd_cas_n && sd_we_n) |=> !wr_data_en);

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

endmodule

// File: tb/sdram_cmd_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b00;
    logic        req_write = 1'b0;
    logic        req_bank = 1'b0;
    logic [10:0] req_row = '0;
    logic [7:0]  req_col = '0;
    logic [1:0]  cfg_rcd = '0;
    logic [1:0]  cfg_cas = '0;
    logic [2:0]  cfg_burst = '0;
    logic        ref_req = 1'b0;
    logic        req_accept, ref_clr, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic        sd_ba, wr_data_en, rd_capture, op_done;
    logic [10:0] sd_addr;

    int total = 0;
    int fails = 0;

    always #2 clk = ~clk;

    sdram_cmd_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .cfg_rcd(cfg_rcd), .cfg_cas(cfg_cas), .cfg_burst(cfg_burst), .ref_req(ref_req),
        .req_accept(req_accept), .ref_clr(ref_clr), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr),
        .wr_data_en(wr_data_en), .rd_capture(rd_capture), .op_done(op_done)
    );

    // ---------------- reference model ----------------
    typedef struct {
        string       tag;
        bit          idle;
        logic [3:0]  cmd;
        logic        ba;
        logic [10:0] addr;
        bit          wr, rd, clr, done;
    } exp_t;

    exp_t exp_q[$];
    exp_t cur;

    function automatic exp_t mk(string tag, bit idle, logic [3:0] cmd, logic ba,
                                logic [10:0] addr, bit wr, bit rd, bit clr, bit done);
        exp_t e;
        e.tag = tag; e.idle = idle; e.cmd = cmd; e.ba = ba; e.addr = addr;
        e.wr = wr; e.rd = rd; e.clr = clr; e.done = done;
        return e;
    endfunction

    // command codes {cs_n,ras_n,cas_n,we_n}
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010, C_REF = 4'b0001, C_MODE = 4'b0000;

    function automatic exp_t idle_entry();
        return mk("R1", 1'b1, C_NOP, 1'b0, 11'h0, 0, 0, 0, 0);
    endfunction

    task automatic push_refresh();
        exp_q.push_back(mk("R4", 0, C_REF, 0, 11'h0, 0, 0, 1, 0));
        exp_q.push_back(mk("R4", 0, C_NOP, 0, 11'h0, 0, 0, 0, 0));
        exp_q.push_back(mk("R9", 1, C_NOP, 0, 11'h0, 0, 0, 0, 1));
    endtask

    task automatic push_op();
        logic [10:0] ca;
        ca = {1'b1, 2'b00, req_col};
        case (req_op)
            2'b10: exp_q.push_back(mk("R2", 0, C_PRE, 0, 11'h400, 0, 0, 0, 0));
            2'b01: exp_q.push_back(mk("R3", 0, C_MODE, 0, req_row, 0, 0, 0, 0));
            2'b11: begin
                exp_q.push_back(mk("R4", 0, C_REF, 0, 11'h0, 0, 0, 1, 0));
                exp_q.push_back(mk("R4", 0, C_NOP, 0, 11'h0, 0, 0, 0, 0));
            end
            default: begin
                exp_q.push_back(mk("R6", 0, C_ACT, req_bank, req_row, 0, 0, 0, 0));
                for (int i = 0; i <= int'(cfg_rcd); i++)
                    exp_q.push_back(mk("R6", 0, C_NOP, 0, 11'h0, 0, 0, 0, 0));
                if (req_write) begin
                    exp_q.push_back(mk("R7", 0, C_WR, req_bank, ca, 1, 0, 0, 0));
                    for (int i = 0; i < int'(cfg_burst); i++)
                        exp_q.push_back(mk("R7", 0, C_NOP, 0, 11'h0, 1, 0, 0, 0));
                end else begin
                    exp_q.push_back(mk("R8", 0, C_RD, req_bank, ca, 0, 0, 0, 0));
                    for (int i = 0; i < int'(cfg_cas); i++)
                        exp_q.push_back(mk("R8", 0, C_NOP, 0, 11'h0, 0, 0, 0, 0));
                    for (int i = 0; i <= int'(cfg_burst); i++)
                        exp_q.push_back(mk("R8", 0, C_NOP, 0, 11'h0, 0, 1, 0, 0));
                end
            end
        endcase
        exp_q.push_back(mk("R9", 1, C_NOP, 0, 11'h0, 0, 0, 0, 1));
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_q.delete();
            cur = idle_entry();
        end else begin
            if (cur.idle && ref_req)        push_refresh();   // R5: refresh wins
            else if (cur.idle && req_valid) push_op();
            if (exp_q.size() > 0) cur = exp_q.pop_front();
            else                  cur = idle_entry();
        end
    end

    // ---------------- per-cycle comparison ----------------
    logic [18:0] act_v, exp_v;
    bit          acc_e;
    always @(negedge clk) begin
        if (rst_n) begin
            act_v = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr,
                     wr_data_en, rd_capture, ref_clr, op_done};
            exp_v = {cur.cmd, cur.ba, cur.addr, 1'(cur.wr), 1'(cur.rd), 1'(cur.clr), 1'(cur.done)};
            total++;
            if (act_v !== exp_v) begin
                fails++;
                $display("FAIL %s pins at %0t actual=%h expected=%h", cur.tag, $time, act_v, exp_v);
            end
            // R10: accept only when idle, valid and no refresh pending
            acc_e = cur.idle && req_valid && !ref_req;
            total++;
            if (req_accept !== acc_e) begin
                fails++;
                $display("FAIL R10 req_accept at %0t actual=%b expected=%b", $time, req_accept, acc_e);
            end
        end
    end

    // ---------------- stimulus ----------------
    task automatic wait_idle();
        @(negedge clk);
        while (!(cur.idle && exp_q.size() == 0)) @(negedge clk);
        #1;
    endtask

    task automatic issue(logic [1:0] op, logic wr, logic bk, logic [10:0] row, logic [7:0] col,
                         logic [1:0] rcd, logic [1:0] cas, logic [2:0] bl);
        wait_idle();
        req_op = op; req_write = wr; req_bank = bk; req_row = row; req_col = col;
        cfg_rcd = rcd; cfg_cas = cas; cfg_burst = bl; req_valid = 1'b1;
        @(negedge clk); #1;
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog (all requirements) actual=hung expected=finished");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        total++;
        if ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_ba, sd_addr, wr_data_en, rd_capture, ref_clr, op_done}
            !== {4'b0111, 1'b0, 11'h0, 4'b0000}) begin
            fails++;
            $display("FAIL R1 reset outputs actual=%b%b%b%b expected=0111", sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n);
        end
        #1 rst_n = 1'b1;
        repeat (3) @(negedge clk);

        issue(2'b10, 0, 0, 11'h0, 8'h0, 0, 0, 0);          // R2 precharge all
        issue(2'b01, 0, 0, 11'h032, 8'h0, 0, 0, 0);        // R3 load mode
        issue(2'b11, 0, 0, 11'h0, 8'h0, 0, 0, 0);          // R4 host refresh

        // R4: refresh taken from timer request
        wait_idle();
        ref_req = 1'b1;
        @(negedge clk);
        while (!ref_clr) @(negedge clk);
        #1 ref_req = 1'b0;

        issue(2'b00, 1, 0, 11'h123, 8'h45, 0, 1, 0);       // R6 R7 single-beat write
        issue(2'b00, 1, 1, 11'h5A5, 8'hC3, 1, 2, 7);       // R7 burst of eight
        issue(2'b00, 0, 0, 11'h7FF, 8'hFF, 0, 0, 0);       // R8 latency one
        issue(2'b00, 0, 1, 11'h2AA, 8'h10, 2, 2, 3);       // R8 latency three

        // R10: requests during a running read are ignored
        issue(2'b00, 0, 0, 11'h0F0, 8'h3C, 1, 1, 7);
        @(negedge clk); #1;
        req_op = 2'b10; req_valid = 1'b1;
        repeat (3) @(negedge clk);
        #1 req_valid = 1'b0;

        // R5: refresh request has priority over a simultaneous access
        wait_idle();
        req_op = 2'b00; req_write = 1'b1; req_bank = 1'b1; req_row = 11'h3C3; req_col = 8'h81;
        cfg_rcd = 2'd3; cfg_burst = 3'd1;
        ref_req = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        while (!ref_clr) @(negedge clk);
        #1 ref_req = 1'b0;
        @(negedge clk);
        while (!req_accept) @(negedge clk);
        #1 req_valid = 1'b0;

        // R11: configuration changes mid-operation have no effect
        issue(2'b00, 0, 1, 11'h155, 8'h77, 2, 1, 3);
        cfg_rcd = 2'd0; cfg_cas = 2'd3; cfg_burst = 3'd0;
        req_row = 11'h000; req_col = 8'h00; req_bank = 1'b0;
        wait_idle();
        repeat (4) @(negedge clk);

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule